// File: doc/BRIEF.md
# Equal Leading-Zero-Count Comparator

This block compares two unsigned operands of one shared width and raises a single flag when both have the same bit length, that is, when their highest set bits sit at the same index. Two all-zero operands have the full width of leading zeros each, so they count as equal. No count of leading zeros is ever formed. A single scan runs down from the most significant bit over the OR of the two operands and finds the first position where either operand has a one. The flag is high when the other operand also has a one at that position, or when neither operand has any set bit.

The block is purely combinational and has no clock or reset. It is meant to end the step loop of an iterative carry-less divider, which stops once the partial remainder and the divisor have the same degree. A parameter selects the scan structure: a linear ripple for small widths, or a logarithmic-depth tree for wide operands.

Top module: `elzc_cmp`

## Requirements
- R1: `same_len` is 1 if and only if the bit length of `op_a` equals the bit length of `op_b`. The bit length is the index of the highest set bit plus one, or 0 for a zero operand.
- R2: When both operands are zero, `same_len` is 1.
- R3: When exactly one operand is zero, `same_len` is 0.
- R4: When bit W-1 is set in both operands, `same_len` is 1 whatever the lower bits are.
- R5: When the highest set bits differ in index, even by one position, `same_len` is 0. In particular, `same_len` is 0 whenever bit W-1 differs between the operands.
- R6: Bits below an operand's highest set bit have no effect on `same_len`.
- R7: The block gives correct results at W = 3, 8 and 64. At W = 3 this is shown over every operand pair.
- R8: Both scan variants, SCAN = SCAN_RIPPLE and SCAN = SCAN_TREE, produce the same flag for every input.
- R9: The output is a combinational function of the present inputs. It settles within the cycle in which the inputs change and holds no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | W | First unsigned operand |
| op_b | input | W | Second unsigned operand |
| same_len | output | 1 | High when both operands have equal bit length |

## Verification
A faulty prefix scan marks the wrong first-set position. The error shows on `same_len` in the same cycle, but only for operand pairs whose leading one falls where the fault is. For this reason the stimulus places leading ones at every index, and at the same index, at adjacent indices and at distant indices. A faulty match reduction or zero detect shows at once on the all-zero and single-zero pairs. Because the block holds no state, every fault is visible within the cycle in which the exposing pair is applied.

// File: rtl/elzc_pkg.sv
package elzc_pkg;
  typedef enum logic {
    SCAN_RIPPLE = 1'b0,
    SCAN_TREE   = 1'b1
  } elzc_scan_e;
endpackage

// File: rtl/elzc_prefix_or.sv
// above[i] is the OR of all input bits strictly above index i.
module elzc_prefix_or
  import elzc_pkg::*;
#(
  parameter int         W    = 8,
  parameter elzc_scan_e SCAN = SCAN_TREE
) (
  input  logic [W-1:0] bits,
  output logic [W-1:0] above
);
  generate
    if (SCAN == SCAN_TREE) begin : g_tree
      localparam int LG = (W > 1) ? $clog2(W) : 1;
      logic [W-1:0] lvl [0:LG];
      assign lvl[0] = bits;
      for (genvar l = 0; l < LG; l++) begin : g_lvl
        for (genvar i = 0; i < W; i++) begin : g_bit
          localparam int J = i + (1 << l);
          if (J < W) begin : g_pair
            assign lvl[l+1][i] = lvl[l][i] | lvl[l][J];
          end else begin : g_pass
            assign lvl[l+1][i] = lvl[l][i];
          end
        end
      end
      assign above = {1'b0, lvl[LG][W-1:1]};
    end else begin : g_ripple
      logic [W-1:0] incl;
      always_comb begin
        incl[W-1] = bits[W-1];
        for (int i = W - 2; i >= 0; i--) begin
          incl[i] = bits[i] | incl[i+1];
        end
      end
      assign above = {1'b0, incl[W-1:1]};
    end
  endgenerate
endmodule

// File: rtl/elzc_first_match.sv
// Flags equality when the first joint set bit is set in both operands,
// or when no bit is set at all.
module elzc_first_match #(
  parameter int W = 8
) (
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic [W-1:0] above,
  output logic         match
);
  logic [W-1:0] joint;
  logic [W-1:0] first;
  logic         hit_both;
  logic         all_zero;

  assign joint    = op_a | op_b;
  assign first    = joint & ~above;
  assign hit_both = |(first & op_a & op_b);
  assign all_zero = ~|joint;
  assign match    = hit_both | all_zero;
endmodule

// File: rtl/elzc_cmp.sv
module elzc_cmp
  import elzc_pkg::*;
#(
  parameter int         W    = 64,
  parameter elzc_scan_e SCAN = SCAN_TREE
) (
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  output logic         same_len
);
  logic [W-1:0] joint;
  logic [W-1:0] above;

  assign joint = op_a | op_b;

  elzc_prefix_or #(.W(W), .SCAN(SCAN)) scan_i (
    .bits  (joint),
    .above (above)
  );

  elzc_first_match #(.W(W)) match_i (
    .op_a  (op_a),
    .op_b  (op_b),
    .above (above),
    .match (same_len)
  );
endmodule

// File: rtl/elzc_cmp_chk.sv
module elzc_cmp_chk #(
  parameter int W = 64
) (
  input logic [W-1:0] op_a,
  input logic [W-1:0] op_b,
  input logic         same_len
);
  always_comb begin
    if (!$isunknown({op_a, op_b, same_len})) begin
      // R2
      both_zero_chk: assert ((op_a != '0) || (op_b != '0) || same_len)
        else $error("both-zero pair not flagged");
      // R3
      one_zero_chk: assert (((op_a == '0) == (op_b == '0)) || !same_len)
        else $error("single zero operand flagged");
      // R4
      top_both_chk: assert (!(op_a[W-1] && op_b[W-1]) || same_len)
        else $error("shared top bit not flagged");
      // R5
      top_diff_chk: assert ((op_a[W-1] == op_b[W-1]) || !same_len)
        else $error("differing top bit flagged");
      // R1
      identical_chk: assert ((op_a != op_b) || same_len)
        else $error("identical operands not flagged");
    end
  end
endmodule

bind elzc_cmp elzc_cmp_chk #(.W(W)) chk_i (
  .op_a     (op_a),
  .op_b     (op_b),
  .same_len (same_len)
);

// File: tb/elzc_cmp_tb_top.sv
module elzc_cmp_tb_top;
  import elzc_pkg::*;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic [63:0] a64 = '0, b64 = '0;
  logic [7:0]  a8 = '0, b8 = '0;
  logic [2:0]  a3 = '0, b3 = '0;
  logic f64t, f64r, f8, f3;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  elzc_cmp #(.W(64), .SCAN(SCAN_TREE))   dut_i      (.op_a(a64), .op_b(b64), .same_len(f64t));
  elzc_cmp #(.W(64), .SCAN(SCAN_RIPPLE)) dut_w64r_i (.op_a(a64), .op_b(b64), .same_len(f64r));
  elzc_cmp #(.W(8),  .SCAN(SCAN_RIPPLE)) dut_w8_i   (.op_a(a8),  .op_b(b8),  .same_len(f8));
  elzc_cmp #(.W(3),  .SCAN(SCAN_TREE))   dut_w3_i   (.op_a(a3),  .op_b(b3),  .same_len(f3));

  function automatic int blen(logic [63:0] v);
    for (int i = 63; i >= 0; i--) if (v[i]) return i + 1;
    return 0;
  endfunction

  function automatic logic [63:0] rnd64();
    return {$urandom(), $urandom()};
  endfunction

  // value with bit length len (0..64), random bits below the leading one
  function automatic logic [63:0] of_len(int len);
    logic [63:0] low;
    if (len == 0) return '0;
    low = (len == 1) ? 64'd0 : (rnd64() & ((64'd1 << (len - 1)) - 64'd1));
    return (64'd1 << (len - 1)) | low;
  endfunction

  task automatic check(string req, int w, logic [63:0] a, logic [63:0] b,
                       logic got, logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s W=%0d a=%h b=%h actual=%b expected=%b", req, w, a, b, got, exp);
    end
  endtask

  task automatic run64(string req, logic [63:0] a, logic [63:0] b);
    logic exp;
    @(posedge clk);
    a64 = a; b64 = b;
    @(negedge clk);
    exp = (blen(a) == blen(b));
    check(req, 64, a, b, f64t, exp);
    check({req, "/R8"}, 64, a, b, f64r, exp);
  endtask

  task automatic run8(string req, logic [7:0] a, logic [7:0] b);
    @(posedge clk);
    a8 = a; b8 = b;
    @(negedge clk);
    check(req, 8, {56'd0, a}, {56'd0, b}, f8, blen({56'd0, a}) == blen({56'd0, b}));
  endtask

  task automatic run3(string req, logic [2:0] a, logic [2:0] b);
    @(posedge clk);
    a3 = a; b3 = b;
    @(negedge clk);
    check(req, 3, {61'd0, a}, {61'd0, b}, f3, blen({61'd0, a}) == blen({61'd0, b}));
  endtask

  initial begin : watchdog
    while (cycles < 200000) begin
      @(posedge clk);
      cycles++;
    end
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    repeat (3) @(posedge clk);
    @(negedge clk);
    // reset state: all operands zero (R2, R9)
    check("R2 reset", 64, '0, '0, f64t, 1'b1);
    check("R2 reset", 8, '0, '0, f8, 1'b1);
    check("R2 reset", 3, '0, '0, f3, 1'b1);
    rst = 1'b0;

    // R7: exhaustive at width 3
    for (int x = 0; x < 8; x++)
      for (int y = 0; y < 8; y++)
        run3("R7 w3", 3'(x), 3'(y));

    // R2 / R3 / R4 / R5 / R6 directed at width 64
    run64("R2", '0, '0);
    run64("R3", 64'd1, '0);
    run64("R3", '0, 64'h8000_0000_0000_0000);
    run64("R4", 64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF);
    run64("R4", 64'hC3A5_0000_0000_0001, 64'h8000_0000_0000_0000);
    run64("R5", 64'd1, 64'd2);
    run64("R5", 64'h8000_0000_0000_0000, 64'h4000_0000_0000_0000);
    run64("R5", 64'h7FFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000);
    run64("R6", 64'h0000_0000_0000_0100, 64'h0000_0000_0000_01FF);
    run64("R1", 64'd1, 64'd1);

    // R1 / R6: every leading-one index, same and neighbouring lengths
    for (int k = 0; k <= 64; k++) begin
      run64("R6 same", of_len(k), of_len(k));
      if (k > 0) run64("R5 adj", of_len(k), of_len(k - 1));
      run64("R1 far", of_len(k), of_len(int'($urandom_range(0, 64))));
    end

    // R1: random width 64 and width 8
    for (int n = 0; n < 300; n++) run64("R1 rnd", rnd64() >> $urandom_range(0, 63),
                                         rnd64() >> $urandom_range(0, 63));
    for (int n = 0; n < 300; n++) run8("R7 w8", 8'($urandom()) >> $urandom_range(0, 7),
                                       8'($urandom()) >> $urandom_range(0, 7));

    // R9: two input changes in a row, output follows each within its cycle
    run8("R9", 8'h80, 8'h81);
    run8("R9", 8'h80, 8'h01);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule